// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one character into one asynchronous serial frame each time it receives a start strobe. The frame opens with a low start bit and carries 5 to 8 data bits, least significant bit first. An optional parity bit can follow: odd, even, forced high (mark) or forced low (space). An optional extra bit, whose value comes in on its own input, can follow that. The frame closes with a high stop period that lasts one, one and a half or two bit times. Every bit lasts sixteen pulses of an oversampling tick that the block receives from outside.

The surrounding logic presents the character, the extra-bit value and the mode fields, then pulses the start strobe while `busy` is low. The block captures all of these on that strobe, so they may change freely while the frame is on the line. When the stop period ends, `busy` falls and `txDone` pulses for one cycle. The next strobe can then be accepted in that same cycle. The captured configuration resets to 8 data bits with no parity, no extra bit and a short stop.

Top module: `uart_frame_tx`

## Requirements
- R1: During and after reset, with no frame accepted, `txLine` is 1, `busy` is 0 and `txDone` is 0.
- R2: A `startStrobe` seen while `busy` is 0 is accepted. In the next cycle `busy` is 1 and `txLine` is 0, and the start bit lasts 16 `tick16` pulses.
- R3: `dataLen` codes 00, 01, 10 and 11 send 5, 6, 7 and 8 data bits. The bits come from `txData` least significant bit first, each lasting 16 ticks.
- R4: When `parityEn` is 1, a parity bit follows the data. `parityType` 00 makes the count of ones over the sent data bits and the parity bit odd, and 01 makes it even. Code 10 always sends 1 and 11 always sends 0. Data bits above the selected length do not affect parity.
- R5: When `extraEn` is 1, the value of `extraBit` is sent for 16 ticks after the data. If parity is also enabled, it comes after the parity bit.
- R6: With `stopLong` 0, the stop period is high for 16 ticks.
- R7: With `stopLong` 1, the stop period is high for 32 ticks when 6, 7 or 8 data bits are sent, and for 24 ticks when 5 are sent.
- R8: The data, the extra-bit value and all mode fields are captured on the accepted strobe. Changing them during a frame does not alter that frame.
- R9: A `startStrobe` that arrives while `busy` is 1 is ignored. The current frame is unchanged and no further frame follows.
- R10: At the clock edge that ends the stop period, `busy` falls and `txDone` rises. `txDone` stays high for exactly one cycle, once per frame.
- R11: While a frame is in progress, `txLine` changes only in the cycle after a `tick16` pulse was seen, apart from the start-bit entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txData | input | 8 | Character to send |
| extraBit | input | 1 | Value of the appended extra bit |
| dataLen | input | 2 | Data length code (00=5 to 11=8 bits) |
| parityEn | input | 1 | Enables the parity bit |
| parityType | input | 2 | 00 odd, 01 even, 10 mark, 11 space |
| extraEn | input | 1 | Enables the extra bit |
| stopLong | input | 1 | Selects the long stop period |
| tick16 | input | 1 | Oversampling tick, 16 per bit time |
| startStrobe | input | 1 | Requests a frame |
| txLine | output | 1 | Serial line, idle high |
| busy | output | 1 | High while a frame is on the line |
| txDone | output | 1 | One-cycle pulse when a frame ends |

## Verification
The assertions assume that `tick16` is a synchronous, one-clock-wide qualifier and that it may stay high in consecutive cycles. They do not assume any minimum tick rate, so they place no bound on frame length in clock cycles. The stimulus drives every input half a cycle away from the active edge and generates the tick at random densities, from sparse to nearly every cycle. Mode fields and strobes are scrambled or repeated while `busy` is high only in the scenarios that test capture and rejection.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_EXTRA  = 3'd4,
    PH_STOP   = 3'd5
  } framePhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic        load;   // capture character and mode
    logic        shift;  // move to next data bit
    framePhase_t phase;  // current part of the frame
  } ctrlStrobes_t;

endpackage

// File: rtl/uft_datapath.sv
module uft_datapath
  import uft_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] txData,
  input  logic              extraBit,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic              parityEn,
  input  logic [1:0]        parityType,
  input  logic              extraEn,
  input  logic              stopLong,
  output logic [LEN_W-1:0]  cfgLen,
  output logic              cfgParity,
  output logic              cfgExtra,
  output logic              cfgStopLong,
  output logic              txLine
);

  logic [DATA_W-1:0] lenMask;
  logic [DATA_W-1:0] shiftReg;
  logic              maskedXor;
  logic              parityCalc;
  logic              parityQ;
  logic              extraQ;

  // mask of the data bits that belong to the selected length
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign lenMask[i] = (32'(i) < (32'(MIN_LEN) + 32'(dataLen)));
  end

  assign maskedXor = ^(txData & lenMask);

  always_comb begin
    case (parityType)
      2'b00:   parityCalc = ~maskedXor;
      2'b01:   parityCalc = maskedXor;
      2'b10:   parityCalc = 1'b1;
      default: parityCalc = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      parityQ     <= 1'b0;
      extraQ      <= 1'b0;
      cfgLen      <= '1;
      cfgParity   <= 1'b0;
      cfgExtra    <= 1'b0;
      cfgStopLong <= 1'b0;
    end else if (strobes.load) begin
      shiftReg    <= txData;
      parityQ     <= parityCalc;
      extraQ      <= extraBit;
      cfgLen      <= dataLen;
      cfgParity   <= parityEn;
      cfgExtra    <= extraEn;
      cfgStopLong <= stopLong;
    end else if (strobes.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    case (strobes.phase)
      PH_START:  txLine = 1'b0;
      PH_DATA:   txLine = shiftReg[0];
      PH_PARITY: txLine = parityQ;
      PH_EXTRA:  txLine = extraQ;
      default:   txLine = 1'b1;
    endcase
  end

endmodule

// File: rtl/uft_ctrl.sv
module uft_ctrl
  import uft_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int LEN_W         = 2,
  parameter int MIN_LEN       = 5,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStrobe,
  input  logic             tick16,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgParity,
  input  logic             cfgExtra,
  input  logic             cfgStopLong,
  output ctrlStrobes_t     strobes,
  output logic             busy,
  output logic             txDone
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W:0] SHORT_TICKS = (CNT_W+1)'(TICKS_PER_BIT);
  localparam logic [CNT_W:0] MID_TICKS   = (CNT_W+1)'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
  localparam logic [CNT_W:0] LONG_TICKS  = (CNT_W+1)'(2 * TICKS_PER_BIT);

  framePhase_t      phase, phaseNext, afterData;
  logic [CNT_W-1:0] tickCnt, cntNext;
  logic [IDX_W-1:0] bitIdx, idxNext, lastIdx;
  logic [CNT_W:0]   stopTicks, bitTicks;
  logic             bitEnd;
  logic             load, shift, doneNext;

  assign lastIdx = IDX_W'(MIN_LEN - 1) + IDX_W'(cfgLen);

  always_comb begin
    if (!cfgStopLong)                 stopTicks = SHORT_TICKS;
    else if (cfgLen == '0)            stopTicks = MID_TICKS;
    else                              stopTicks = LONG_TICKS;
  end

  assign bitTicks = (phase == PH_STOP) ? stopTicks : SHORT_TICKS;
  assign bitEnd   = ({1'b0, tickCnt} == (bitTicks - 1'b1));

  always_comb begin
    if (cfgParity)     afterData = PH_PARITY;
    else if (cfgExtra) afterData = PH_EXTRA;
    else               afterData = PH_STOP;
  end

  always_comb begin
    phaseNext = phase;
    cntNext   = tickCnt;
    idxNext   = bitIdx;
    load      = 1'b0;
    shift     = 1'b0;
    doneNext  = 1'b0;
    if (phase == PH_IDLE) begin
      if (startStrobe) begin
        phaseNext = PH_START;
        cntNext   = '0;
        load      = 1'b1;
      end
    end else if (tick16) begin
      if (bitEnd) begin
        cntNext = '0;
        case (phase)
          PH_START: begin
            phaseNext = PH_DATA;
            idxNext   = '0;
          end
          PH_DATA: begin
            if (bitIdx == lastIdx) begin
              phaseNext = afterData;
            end else begin
              idxNext = bitIdx + 1'b1;
              shift   = 1'b1;
            end
          end
          PH_PARITY: phaseNext = cfgExtra ? PH_EXTRA : PH_STOP;
          PH_EXTRA:  phaseNext = PH_STOP;
          default: begin
            phaseNext = PH_IDLE;
            doneNext  = 1'b1;
          end
        endcase
      end else begin
        cntNext = tickCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      txDone  <= 1'b0;
    end else begin
      phase   <= phaseNext;
      tickCnt <= cntNext;
      bitIdx  <= idxNext;
      txDone  <= doneNext;
    end
  end

  assign busy          = (phase != PH_IDLE);
  assign strobes.load  = load;
  assign strobes.shift = shift;
  assign strobes.phase = phase;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int MIN_LEN       = 5,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              extraBit,
  input  logic [1:0]        dataLen,
  input  logic              parityEn,
  input  logic [1:0]        parityType,
  input  logic              extraEn,
  input  logic              stopLong,
  input  logic              tick16,
  input  logic              startStrobe,
  output logic              txLine,
  output logic              busy,
  output logic              txDone
);

  localparam int LEN_W = 2;

  ctrlStrobes_t     strobes;
  logic [LEN_W-1:0] cfgLen;
  logic             cfgParity, cfgExtra, cfgStopLong;

  uft_ctrl #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .tick16(tick16),
    .cfgLen(cfgLen), .cfgParity(cfgParity), .cfgExtra(cfgExtra),
    .cfgStopLong(cfgStopLong), .strobes(strobes), .busy(busy), .txDone(txDone)
  );

  uft_datapath #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txData(txData),
    .extraBit(extraBit), .dataLen(dataLen), .parityEn(parityEn),
    .parityType(parityType), .extraEn(extraEn), .stopLong(stopLong),
    .cfgLen(cfgLen), .cfgParity(cfgParity), .cfgExtra(cfgExtra),
    .cfgStopLong(cfgStopLong), .txLine(txLine)
  );

endmodule

// File: rtl/uft_checker.sv
module uft_checker (
  input logic clk,
  input logic rstN,
  input logic startStrobe,
  input logic tick16,
  input logic txLine,
  input logic busy,
  input logic txDone
);

  // line rests high whenever no frame is in progress
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startStrobe) |=> (busy && !txLine));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (!busy && $past(busy)));

  assert_done_after_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> $past(tick16));

  assert_line_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(tick16)) |-> $stable(txLine));

endmodule

bind uart_frame_tx uft_checker chk (
  .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .tick16(tick16),
  .txLine(txLine), .busy(busy), .txDone(txDone)
);

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/1ps
module tb_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] txData = '0;
  logic       extraBit = 1'b0;
  logic [1:0] dataLen = 2'b11;
  logic       parityEn = 1'b0;
  logic [1:0] parityType = 2'b00;
  logic       extraEn = 1'b0;
  logic       stopLong = 1'b0;
  logic       tick16 = 1'b0;
  logic       startStrobe = 1'b0;
  logic       txLine, busy, txDone;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int tickDiv = 3;
  int doneSeen = 0;
  string curReq = "R1";

  // reference model state
  int  qLvl[$];
  int  qDur[$];
  int  remTicks = 0;
  bit  expDone = 1'b0;

  always #4 clk = ~clk;

  uart_frame_tx dut (
    .clk(clk), .rstN(rstN), .txData(txData), .extraBit(extraBit),
    .dataLen(dataLen), .parityEn(parityEn), .parityType(parityType),
    .extraEn(extraEn), .stopLong(stopLong), .tick16(tick16),
    .startStrobe(startStrobe), .txLine(txLine), .busy(busy), .txDone(txDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural frame model, advanced on every clock
  always @(posedge clk) begin
    expDone = 1'b0;
    if (!rstN) begin
      qLvl.delete(); qDur.delete(); remTicks = 0;
    end else if (qLvl.size() > 0) begin
      if (tick16) begin
        remTicks--;
        if (remTicks == 0) begin
          void'(qLvl.pop_front()); void'(qDur.pop_front());
          if (qLvl.size() == 0) expDone = 1'b1;
          else remTicks = qDur[0];
        end
      end
    end else if (startStrobe) begin
      int n;
      int ones;
      n = 5 + int'(dataLen);
      ones = 0;
      qLvl.push_back(0); qDur.push_back(16);
      for (int i = 0; i < n; i++) begin
        qLvl.push_back(int'(txData[i])); qDur.push_back(16);
        ones += int'(txData[i]);
      end
      if (parityEn) begin
        case (parityType)
          2'b00: qLvl.push_back((ones % 2 == 0) ? 1 : 0);
          2'b01: qLvl.push_back(ones % 2);
          2'b10: qLvl.push_back(1);
          default: qLvl.push_back(0);
        endcase
        qDur.push_back(16);
      end
      if (extraEn) begin qLvl.push_back(int'(extraBit)); qDur.push_back(16); end
      qLvl.push_back(1);
      qDur.push_back(!stopLong ? 16 : (n == 5 ? 24 : 32));
      remTicks = 16;
    end
  end

  always @(posedge clk) if (rstN && txDone) doneSeen++;

  // compare outputs against model away from the edge
  always @(negedge clk) begin
    if (rstN) begin
      int eLine;
      bit eBusy;
      eBusy = (qLvl.size() > 0);
      eLine = eBusy ? qLvl[0] : 1;
      check(txLine == eLine[0], curReq, "txLine", int'(txLine), eLine);
      check(busy == eBusy, curReq, "busy", int'(busy), int'(eBusy));
      check(txDone == expDone, "R10", "txDone", int'(txDone), int'(expDone));
    end
  end

  // tick generator
  always @(negedge clk) tick16 <= ($urandom % tickDiv) == 0;

  task automatic sendFrame(input logic [7:0] d, input logic [1:0] len, input logic pe,
                           input logic [1:0] pt, input logic xe, input logic xb,
                           input logic sl, input bit scramble, input bit lateStrobe,
                           input string req);
    int k;
    @(negedge clk);
    curReq = req;
    doneSeen = 0;
    txData = d; dataLen = len; parityEn = pe; parityType = pt;
    extraEn = xe; extraBit = xb; stopLong = sl; startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
    k = 0;
    while (busy) begin
      @(negedge clk);
      k++;
      if (scramble) begin
        txData = 8'($urandom); dataLen = 2'($urandom); parityEn = 1'($urandom);
        parityType = 2'($urandom); extraEn = 1'($urandom);
        extraBit = 1'($urandom); stopLong = 1'($urandom);
      end
      startStrobe = lateStrobe && (k % 40 == 5);
    end
    startStrobe = 1'b0;
    repeat (2) @(negedge clk);
    check(doneSeen == 1, "R10", "done pulses per frame", doneSeen, 1);
    if (lateStrobe) check(busy == 1'b0, "R9", "no frame after ignored strobe", int'(busy), 0);
    repeat ($urandom % 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txLine == 1'b1, "R1", "line in reset", int'(txLine), 1);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(txDone == 1'b0, "R1", "done in reset", int'(txDone), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(txLine == 1'b1 && busy == 1'b0, "R1", "idle after reset",
          int'({txLine, busy}), 2);

    for (int l = 0; l < 4; l++) begin
      sendFrame(8'hA5, 2'(l), 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 0, 0, "R3");
      sendFrame(8'h3C, 2'(l), 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 0, 0, "R3");
    end
    for (int t = 0; t < 4; t++) begin
      sendFrame(8'hE0, 2'b00, 1'b1, 2'(t), 1'b0, 1'b0, 1'b0, 0, 0, "R4");
      sendFrame(8'h17, 2'b10, 1'b1, 2'(t), 1'b0, 1'b0, 1'b0, 0, 0, "R4");
      sendFrame(8'hFF, 2'b11, 1'b1, 2'(t), 1'b0, 1'b0, 1'b0, 0, 0, "R4");
    end
    sendFrame(8'h55, 2'b11, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 0, 0, "R5");
    sendFrame(8'h55, 2'b01, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 0, 0, "R5");
    sendFrame(8'h0F, 2'b00, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 0, 0, "R5");
    sendFrame(8'hF0, 2'b11, 1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 0, 0, "R5");
    sendFrame(8'h81, 2'b10, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 0, 0, "R6");
    for (int l = 0; l < 4; l++)
      sendFrame(8'hC3, 2'(l), 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 0, 0, "R7");
    for (int i = 0; i < 6; i++)
      sendFrame(8'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 1, 0, "R8");
    for (int i = 0; i < 4; i++)
      sendFrame(8'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 0, 1, "R9");
    tickDiv = 7;
    for (int i = 0; i < 4; i++)
      sendFrame(8'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 0, 0, "R11");
    tickDiv = 1;
    for (int i = 0; i < 6; i++)
      sendFrame(8'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 0, 0, "R2");
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule